// File: doc/BRIEF.md
# Table jump target fetch unit

This unit carries out the two compressed table-jump instructions. It accepts one 16-bit instruction at a time, together with the program counter of that instruction and the base address of the jump table. It then picks out the table index, reads one 32-bit table entry through a memory read port, and produces a redirect of the program counter. The non-linking and linking forms share one opcode and are told apart only by the range of the index. The linking form also writes the return address into register x1.

The instruction input and the memory request and response channels are valid/ready streams. The instruction handshake takes place when `in_valid` and `in_ready` are both high on a rising edge. `in_ready` is high only while the unit is idle, so one instruction is in flight at most. The memory request holds its address until `mem_req_ready` accepts it. The response is taken only while `mem_rsp_ready` is high. The redirect and link-write outputs are plain one-cycle strobes with no back-pressure.

Top module: `tj_unit`

## Requirements
- R1: After reset, `in_ready` is 1 and `mem_req_valid`, `mem_rsp_ready`, `redir_valid` and `link_we` are 0.
- R2: An instruction whose bits 15:13 are 101, bits 1:0 are 10 and bits 12:7 are all zero is a non-linking jump. Its index is bits 6:2 (0 to 31). The request address is `tbl_base + 4*index`, and `link_we` stays 0.
- R3: An instruction with bits 15:13 = 101, bits 1:0 = 10 and bits 12:10 = 000 whose 8-bit index in bits 9:2 is at least 32 is a linking jump. The request address is `tbl_base + 4*index`. In the redirect cycle, `link_we` is 1, `link_rd` is 1 and `link_data` is `in_pc + 2`.
- R4: Any other instruction is consumed by its handshake and then dropped. No memory request, no redirect and no link write follow it, and `in_ready` is high again in the next cycle.
- R5: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid and its address does not change.
- R6: `redir_valid` is 1 in exactly the cycle after the response handshake and at no other time. `mem_rsp_ready` is 1 only while a response is awaited.
- R7: `redir_pc` is the fetched entry with bit 0 forced to 0.
- R8: The entry address wraps modulo 2^32 when `tbl_base + 4*index` overflows.
- R9: `in_ready` is 0 from the cycle after an accepted jump until the cycle after its redirect.
- R10: The unit never issues more than one memory read per instruction and issues no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_instr | input | 16 | Compressed instruction |
| in_pc | input | 32 | Address of the instruction |
| tbl_base | input | 32 | Base address of the jump table |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Unit awaiting read data |
| mem_rsp_data | input | 32 | Fetched table entry |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | 32 | New program counter |
| link_we | output | 1 | Return address write enable |
| link_rd | output | 5 | Destination register number (always 1) |
| link_data | output | 32 | Return address |

## Verification
The bench sweeps every 8-bit index and so crosses the boundary between index 31 and index 32. A unit that split the two forms at the wrong point would link on a plain jump, or miss the link on the linking form. Encodings with stray bits in 12:10 or 12:7, or with a wrong opcode, are sent to check that they are dropped. A loose decoder would issue a memory read for them. Table bases close to the top of the address space check that the address wraps, and random stall lengths on both memory channels check that the address holds steady under back-pressure. Entries with bit 0 set check that the redirect clears that bit, and the redirect strobe is timed against the response edge to catch a unit that redirects a cycle early or late.

// File: rtl/tj_pkg.sv
package tj_pkg;
  localparam int TJ_IDX_W    = 8;
  localparam int TJ_LINK_MIN = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } tj_state_e;

  typedef struct packed {
    logic                legal;
    logic                link;
    logic [TJ_IDX_W-1:0] idx;
  } tj_dec_t;
endpackage

// File: rtl/tj_decode.sv
module tj_decode
  import tj_pkg::*;
(
  input  logic [15:0] instr,
  output tj_dec_t     dec
);
  logic op_ok;
  logic [TJ_IDX_W-1:0] idx_raw;

  always_comb begin
    op_ok     = (instr[15:13] == 3'b101) && (instr[1:0] == 2'b10) &&
                (instr[12:10] == 3'b000);
    idx_raw   = instr[9:2];
    dec.idx   = idx_raw;
    dec.link  = op_ok && (idx_raw >= TJ_IDX_W'(TJ_LINK_MIN));
    // an index below the split point only fits when bits 9:7 are zero
    dec.legal = op_ok;
  end
endmodule

// File: rtl/tj_addr.sv
module tj_addr
  import tj_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]     base,
  input  logic [TJ_IDX_W-1:0] idx,
  input  logic [XLEN-1:0]     pc,
  output logic [XLEN-1:0]     entry_addr,
  output logic [XLEN-1:0]     ret_addr
);
  localparam int SHIFT = $clog2(XLEN / 8);
  logic [XLEN-1:0] offset;

  always_comb begin
    offset     = {{(XLEN-TJ_IDX_W){1'b0}}, idx} << SHIFT;
    entry_addr = base + offset;
    ret_addr   = pc + XLEN'(2);
  end
endmodule

// File: rtl/tj_ctrl.sv
module tj_ctrl
  import tj_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  logic      legal,
  input  logic      req_ready,
  input  logic      rsp_valid,
  output tj_state_e state
);
  tj_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (take && legal) nxt = ST_REQ;
      ST_REQ:  if (req_ready)     nxt = ST_WAIT;
      ST_WAIT: if (rsp_valid)     nxt = ST_DONE;
      ST_DONE:                    nxt = ST_IDLE;
      default:                    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // R10
  req_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ && req_ready) |=> (state != ST_REQ));
  // R9
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> (state == ST_IDLE));
endmodule

// File: rtl/tj_unit.sv
module tj_unit
  import tj_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [15:0]     in_instr,
  input  logic [XLEN-1:0] in_pc,
  input  logic [XLEN-1:0] tbl_base,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  output logic            mem_rsp_ready,
  input  logic [XLEN-1:0] mem_rsp_data,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output logic            link_we,
  output logic [4:0]      link_rd,
  output logic [XLEN-1:0] link_data
);
  localparam logic [4:0] RA_REG = 5'd1;

  tj_dec_t         dec;
  tj_state_e       state;
  logic [XLEN-1:0] ent_addr, ret_addr;
  logic [XLEN-1:0] addr_q, ret_q, tgt_q;
  logic            link_q;
  logic            take;

  tj_decode u_dec (.instr(in_instr), .dec(dec));

  tj_addr #(.XLEN(XLEN)) u_addr (
    .base(tbl_base), .idx(dec.idx), .pc(in_pc),
    .entry_addr(ent_addr), .ret_addr(ret_addr)
  );

  assign take = in_valid && in_ready;

  tj_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .take(take), .legal(dec.legal),
    .req_ready(mem_req_ready), .rsp_valid(mem_rsp_valid), .state(state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      ret_q  <= '0;
      tgt_q  <= '0;
      link_q <= 1'b0;
    end else begin
      if (take && dec.legal) begin
        addr_q <= ent_addr;
        ret_q  <= ret_addr;
        link_q <= dec.link;
      end
      if (state == ST_WAIT && mem_rsp_valid)
        tgt_q <= {mem_rsp_data[XLEN-1:1], 1'b0};
    end
  end

  always_comb begin
    in_ready      = (state == ST_IDLE);
    mem_req_valid = (state == ST_REQ);
    mem_req_addr  = addr_q;
    mem_rsp_ready = (state == ST_WAIT);
    redir_valid   = (state == ST_DONE);
    redir_pc      = tgt_q;
    link_we       = (state == ST_DONE) && link_q;
    link_rd       = RA_REG;
    link_data     = ret_q;
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R6
  redir_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_ready) |=> redir_valid);
  // R6
  redir_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> $past(mem_rsp_valid && mem_rsp_ready));
  // R7
  pc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (redir_pc[0] == 1'b0));
  // R3
  link_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> redir_valid);
  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, mem_req_valid, mem_rsp_ready, redir_valid}));
endmodule

// File: tb/sim_tj_unit.sv
module sim_tj_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_instr = '0;
  logic [31:0] in_pc = '0;
  logic [31:0] tbl_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic        redir_valid;
  logic [31:0] redir_pc;
  logic        link_we;
  logic [4:0]  link_rd;
  logic [31:0] link_data;

  int checks = 0;
  int errors = 0;
  int seed_q = 7;

  always #5 clk = ~clk;

  tj_unit u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nxt_rand(input int m);
    seed_q = seed_q * 1103515245 + 12345;
    return ((seed_q >>> 16) & 32'h7fff) % m;
  endfunction

  task automatic run_jump(input logic [15:0] ins, input logic [31:0] pc,
                          input logic [31:0] base, input bit legal,
                          input bit link, input int idx, input logic [31:0] ent);
    logic [31:0] exp_addr;
    int dq, dr;
    exp_addr = base + 32'(idx) * 32'd4;
    dq = nxt_rand(3);
    dr = nxt_rand(3);
    @(negedge clk);
    chk(in_ready, "R9 idle ready", 32'(in_ready), 32'd1);
    in_valid = 1'b1; in_instr = ins; in_pc = pc; tbl_base = base;
    @(negedge clk);
    in_valid = 1'b0;
    if (!legal) begin
      chk(!mem_req_valid && in_ready && !redir_valid && !link_we,
          "R4 dropped", {mem_req_valid, in_ready, redir_valid, link_we}, 32'h4);
      @(negedge clk);
      chk(!mem_req_valid && !redir_valid, "R4 stays quiet",
          {mem_req_valid, redir_valid}, 32'h0);
      return;
    end
    chk(mem_req_valid && !in_ready, "R9 busy request",
        {mem_req_valid, in_ready}, 32'h2);
    chk(mem_req_addr == exp_addr, link ? "R3 addr" : "R2 addr",
        mem_req_addr, exp_addr);
    for (int k = 0; k < dq; k++) begin
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == exp_addr, "R5 hold", mem_req_addr, exp_addr);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(!mem_req_valid && mem_rsp_ready, "R10 single request",
        {mem_req_valid, mem_rsp_ready}, 32'h1);
    for (int k = 0; k < dr; k++) begin
      @(negedge clk);
      chk(!redir_valid && mem_rsp_ready, "R6 no early redirect",
          {redir_valid, mem_rsp_ready}, 32'h1);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = ent;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk(redir_valid && !mem_rsp_ready, "R6 redirect timing",
        {redir_valid, mem_rsp_ready}, 32'h2);
    chk(redir_pc == (ent & 32'hFFFF_FFFE), "R7 target", redir_pc, ent & 32'hFFFF_FFFE);
    if (link) begin
      chk(link_we && link_rd == 5'd1 && link_data == pc + 32'd2, "R3 link",
          link_data, pc + 32'd2);
    end else begin
      chk(!link_we, "R2 no link", 32'(link_we), 32'd0);
    end
    @(negedge clk);
    chk(!redir_valid && !link_we && in_ready, "R6 single strobe",
        {redir_valid, link_we, in_ready}, 32'h1);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] base, pc, ent;
    logic [15:0] ins;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !mem_req_valid && !mem_rsp_ready && !redir_valid && !link_we,
        "R1 reset state",
        {in_ready, mem_req_valid, mem_rsp_ready, redir_valid, link_we}, 32'h10);
    // every index, both forms split at 32
    for (int i = 0; i < 256; i++) begin
      base = 32'h0001_0000 + 32'(i) * 32'h40;
      pc   = 32'h8000_0000 + 32'(i) * 32'd6;
      ent  = {16'h2000, 8'(i), 8'(i * 3 + 1)};
      ins  = {3'b101, 3'b000, 8'(i), 2'b10};
      run_jump(ins, pc, base, 1'b1, i >= 32, i, ent);
    end
    // R8 wraparound near the top of the address space
    for (int i = 28; i < 40; i++) begin
      base = 32'hFFFF_FFC0;
      ins  = {3'b101, 3'b000, 8'(i), 2'b10};
      run_jump(ins, 32'hFFFF_FFFE, base, 1'b1, i >= 32, i, 32'h1234_5671);
    end
    // R4 stray bits in 12:10 and wrong opcode fields
    for (int b = 1; b < 8; b++) begin
      ins = {3'b101, 3'(b), 8'd5, 2'b10};
      run_jump(ins, 32'h100, 32'h200, 1'b0, 1'b0, 0, 32'h0);
    end
    for (int b = 0; b < 8; b++) begin
      if (b == 5) continue;
      ins = {3'(b), 3'b000, 8'd40, 2'b10};
      run_jump(ins, 32'h100, 32'h200, 1'b0, 1'b0, 0, 32'h0);
    end
    for (int b = 0; b < 4; b++) begin
      if (b == 2) continue;
      ins = {3'b101, 3'b000, 8'd3, 2'(b)};
      run_jump(ins, 32'h100, 32'h200, 1'b0, 1'b0, 0, 32'h0);
    end
    // back-to-back legal after illegal
    run_jump({3'b101, 3'b000, 8'd31, 2'b10}, 32'h40, 32'h0, 1'b1, 1'b0, 31, 32'hFFFF_FFFF);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule